// File: doc/BRIEF.md
# Deep-Sleep Wake-Up Controller

This block gathers wake requests from peripheral sources while the chip is held in its deepest sleep state and decides when, and into which power state, the chip comes back. Some of the sources are single-cycle strobes from blocks outside this one: a temperature-delta result, a supply-voltage-delta result, main-supply restoration, an RTC interval tick and an RTC alarm. The others are asynchronous pins: two external interrupt lines, a UART receive line and an active-low external reset pin. Each pin passes through its own synchronizer and edge detector.

Maskable sources latch into sticky flags that software clears by writing a one. Whether a latched flag counts as a wake request depends on its enable. Main-supply restoration cannot be masked. The two interrupt pins wake the chip directly and never touch any flag. The reset pin returns the chip to the intermediate low-power state and not to the active state. A sleep request is refused while any flag that could wake the chip is still set, so a stale event cannot make the chip bounce straight out of sleep.

Top module: `wake_ctrl`

## Requirements
- R1: After reset, `pwr_state_o` is 00 (active), `wake_o` and `sleep_rej_o` are 0, and registers 0 to 4 read 0. Power-state encoding: 00 active, 01 intermediate, 10 deep sleep.
- R2: A one-cycle `sleep_req_i` outside deep sleep, with no armed flag set, puts the chip in deep sleep on the next clock edge and clears `sleep_rej_o`.
- R3: A sleep request made while any armed flag is set leaves the power state unchanged and sets `sleep_rej_o`. A flag is armed when it is set and its enable is on. A set flag whose enable is off does not block sleep.
- R4: A supply-restore strobe sets bit 7 of register 0 and the main-rail status at bit 6 of register 4. The restore flag wakes the chip from deep sleep with no enable. The status bit is read-only and clears only on reset.
- R5: A voltage-delta strobe always sets bit 3 of register 0. The flag wakes the chip only while bit 3 of register 1 is 1, and it also wakes the chip if that enable is turned on during deep sleep.
- R6: A temperature-delta strobe sets bit 0 of register 0 and wakes the chip only while the measurement enable, bit 0 of register 1, is 1. With the enable at 0 the strobe is ignored.
- R7: The RTC interval and alarm strobes set bits 2 and 6 of register 2. They wake the chip only when the matching enable is 1: bit 6 of register 3 for the interval and bit 7 of register 3 for the alarm.
- R8: External pin 0 wakes the chip when bit 0 of register 3 is 1, on the edge chosen by bit 4 of register 3 (1 = rising, 0 = falling). A pin wake sets no bit in registers 0, 2 or 4.
- R9: External pin 1 wakes the chip when bits 3:1 of register 3 match 11x, that is bits 3 and 2 set and bit 1 ignored. The edge is chosen by bit 5 of register 3.
- R10: When bits 1:0 of register 4 equal 11, either edge on the receive line sets bit 7 of register 4 and wakes the chip. Any other value of those bits disables this source.
- R11: While the chip is in deep sleep, a low on `ext_rst_ni` moves it to the intermediate state with a wake pulse. This source takes priority over every other source in the same cycle.
- R12: `wake_o` is a one-cycle pulse issued only when the chip leaves deep sleep, so at most once per sleep episode. It is high in the second cycle after a strobe's cycle. For pins it is high in the cycle after the third clock edge that follows the pin change.
- R13: Flags clear when a 1 is written to their bit at register addresses 0, 2 and 4. If an event arrives in the same cycle as a clear of its flag, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| temp_evt_i | input | 1 | Temperature-delta strobe |
| vdelta_evt_i | input | 1 | Supply-voltage-delta strobe |
| supply_evt_i | input | 1 | Main-supply restoration strobe |
| rtc_tick_evt_i | input | 1 | RTC interval strobe |
| rtc_alarm_evt_i | input | 1 | RTC alarm strobe |
| ext0_pin_i | input | 1 | External interrupt pin 0, asynchronous |
| ext1_pin_i | input | 1 | External interrupt pin 1, asynchronous |
| rx_pin_i | input | 1 | UART receive line, asynchronous |
| ext_rst_ni | input | 1 | External reset pin, active low, asynchronous |
| sleep_req_i | input | 1 | Request to enter deep sleep |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Register write address |
| wr_data_i | input | 8 | Register write data |
| rd_addr_i | input | ADDR_W | Register read address |
| rd_data_o | output | 8 | Register read data, combinational; address 5 returns {sleep_rej, power state} |
| pwr_state_o | output | 2 | Current power state |
| wake_o | output | 1 | Wake pulse |
| sleep_rej_o | output | 1 | Last sleep request was refused |

## Verification
The bench builds the block with `SYNC_STAGES = 2` and `ADDR_W = 3`. With two synchronizer stages a pin edge reaches the state machine in three clock edges, so the bench can pin down exact wake latencies. It can also line up the reset pin and a supply-restore strobe so that both reach the state machine in the same cycle, which exercises the priority rule. A table of vectors resets the block and drives each source with its enable on and then off. Directed cases cover refused sleep entry, a clear racing an event, and an enable turned on during sleep.

// File: rtl/wake_pkg.sv
package wake_pkg;
  localparam int unsigned REG_W = 8;

  typedef enum logic [1:0] {
    PWR_ACTIVE = 2'b00,
    PWR_LIGHT  = 2'b01,
    PWR_DEEP   = 2'b10
  } pwr_state_e;

  localparam int unsigned REG_PM_FLAG  = 0;
  localparam int unsigned REG_PM_EN    = 1;
  localparam int unsigned REG_RTC_FLAG = 2;
  localparam int unsigned REG_WAKE_CFG = 3;
  localparam int unsigned REG_PERIPH   = 4;
  localparam int unsigned REG_STATUS   = 5;

  localparam int unsigned PMF_SUPPLY = 7;
  localparam int unsigned PMF_VDELTA = 3;
  localparam int unsigned PMF_TEMP   = 0;
  localparam int unsigned PME_VDELTA = 3;
  localparam int unsigned PME_TEMP   = 0;
  localparam int unsigned RTCF_ALARM = 6;
  localparam int unsigned RTCF_TICK  = 2;
  localparam int unsigned PER_RXF    = 7;
  localparam int unsigned PER_RAIL   = 6;

  typedef struct packed {
    logic       alarm_en;
    logic       tick_en;
    logic       ext1_rise;
    logic       ext0_rise;
    logic [2:0] ext1_code;
    logic       ext0_en;
  } wake_cfg_t;

  typedef struct packed {
    logic temp;
    logic vdelta;
    logic supply;
    logic tick;
    logic alarm;
    logic rx;
  } wake_flags_t;
endpackage

// File: rtl/wake_pin_sync.sv
module wake_pin_sync #(
  parameter int unsigned N      = 4,
  parameter int unsigned STAGES = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  for (genvar g = 0; g < N; g++) begin : g_pin
    // chain[STAGES-1] is the synchronized level, chain[STAGES] its history
    logic [STAGES:0] chain;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain <= {(STAGES+1){RST_VAL[g]}};
      else         chain <= {chain[STAGES-1:0], pin_i[g]};
    end
    assign lvl_o[g]  = chain[STAGES-1];
    assign rise_o[g] = chain[STAGES-1] & ~chain[STAGES];
    assign fall_o[g] = ~chain[STAGES-1] & chain[STAGES];
  end
endmodule

// File: rtl/wake_regs.sv
module wake_regs
  import wake_pkg::*;
#(
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [REG_W-1:0]  wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [REG_W-1:0]  rd_data_o,
  input  logic              temp_evt_i,
  input  logic              vdelta_evt_i,
  input  logic              supply_evt_i,
  input  logic              tick_evt_i,
  input  logic              alarm_evt_i,
  input  logic              rx_edge_i,
  input  logic [1:0]        state_i,
  input  logic              sleep_rej_i,
  output wake_flags_t       flags_o,
  output logic              temp_en_o,
  output logic              vdelta_en_o,
  output wake_cfg_t         cfg_o,
  output logic [1:0]        rx_mode_o
);
  localparam logic [ADDR_W-1:0] A_PMF = ADDR_W'(REG_PM_FLAG);
  localparam logic [ADDR_W-1:0] A_PME = ADDR_W'(REG_PM_EN);
  localparam logic [ADDR_W-1:0] A_RTC = ADDR_W'(REG_RTC_FLAG);
  localparam logic [ADDR_W-1:0] A_CFG = ADDR_W'(REG_WAKE_CFG);
  localparam logic [ADDR_W-1:0] A_PER = ADDR_W'(REG_PERIPH);
  localparam logic [ADDR_W-1:0] A_STS = ADDR_W'(REG_STATUS);

  wake_flags_t flags_q;
  wake_cfg_t   cfg_q;
  logic        temp_en_q, vdelta_en_q, rail_q;
  logic [1:0]  rx_mode_q;
  logic        hit_pmf, hit_pme, hit_rtc, hit_cfg, hit_per;

  assign hit_pmf = wr_en_i && (wr_addr_i == A_PMF);
  assign hit_pme = wr_en_i && (wr_addr_i == A_PME);
  assign hit_rtc = wr_en_i && (wr_addr_i == A_RTC);
  assign hit_cfg = wr_en_i && (wr_addr_i == A_CFG);
  assign hit_per = wr_en_i && (wr_addr_i == A_PER);

  // event beats a same-cycle clear
  function automatic logic w1c(logic cur, logic evt, logic clr);
    return evt | (cur & ~clr);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q     <= '0;
      cfg_q       <= '0;
      temp_en_q   <= 1'b0;
      vdelta_en_q <= 1'b0;
      rail_q      <= 1'b0;
      rx_mode_q   <= 2'b00;
    end else begin
      flags_q.temp   <= w1c(flags_q.temp, temp_evt_i & temp_en_q,
                            hit_pmf & wr_data_i[PMF_TEMP]);
      flags_q.vdelta <= w1c(flags_q.vdelta, vdelta_evt_i,
                            hit_pmf & wr_data_i[PMF_VDELTA]);
      flags_q.supply <= w1c(flags_q.supply, supply_evt_i,
                            hit_pmf & wr_data_i[PMF_SUPPLY]);
      flags_q.tick   <= w1c(flags_q.tick, tick_evt_i,
                            hit_rtc & wr_data_i[RTCF_TICK]);
      flags_q.alarm  <= w1c(flags_q.alarm, alarm_evt_i,
                            hit_rtc & wr_data_i[RTCF_ALARM]);
      flags_q.rx     <= w1c(flags_q.rx, rx_edge_i,
                            hit_per & wr_data_i[PER_RXF]);
      rail_q         <= rail_q | supply_evt_i;
      if (hit_pme) begin
        temp_en_q   <= wr_data_i[PME_TEMP];
        vdelta_en_q <= wr_data_i[PME_VDELTA];
      end
      if (hit_cfg) cfg_q <= wake_cfg_t'(wr_data_i);
      if (hit_per) rx_mode_q <= wr_data_i[1:0];
    end
  end

  always_comb begin
    rd_data_o = '0;
    case (rd_addr_i)
      A_PMF: begin
        rd_data_o[PMF_SUPPLY] = flags_q.supply;
        rd_data_o[PMF_VDELTA] = flags_q.vdelta;
        rd_data_o[PMF_TEMP]   = flags_q.temp;
      end
      A_PME: begin
        rd_data_o[PME_VDELTA] = vdelta_en_q;
        rd_data_o[PME_TEMP]   = temp_en_q;
      end
      A_RTC: begin
        rd_data_o[RTCF_ALARM] = flags_q.alarm;
        rd_data_o[RTCF_TICK]  = flags_q.tick;
      end
      A_CFG: rd_data_o = cfg_q;
      A_PER: begin
        rd_data_o[PER_RXF]  = flags_q.rx;
        rd_data_o[PER_RAIL] = rail_q;
        rd_data_o[1:0]      = rx_mode_q;
      end
      A_STS: rd_data_o[2:0] = {sleep_rej_i, state_i};
      default: rd_data_o = '0;
    endcase
  end

  assign flags_o     = flags_q;
  assign cfg_o       = cfg_q;
  assign temp_en_o   = temp_en_q;
  assign vdelta_en_o = vdelta_en_q;
  assign rx_mode_o   = rx_mode_q;
endmodule

// File: rtl/wake_seq.sv
module wake_seq
  import wake_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sleep_req_i,
  input  logic       pending_i,
  input  logic       wake_evt_i,
  input  logic       rst_pin_low_i,
  output pwr_state_e state_o,
  output logic       wake_o,
  output logic       sleep_rej_o
);
  pwr_state_e state_q;
  logic       wake_q, rej_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PWR_ACTIVE;
      wake_q  <= 1'b0;
      rej_q   <= 1'b0;
    end else begin
      wake_q <= 1'b0;
      if (state_q == PWR_DEEP) begin
        if (rst_pin_low_i) begin
          state_q <= PWR_LIGHT;
          wake_q  <= 1'b1;
        end else if (wake_evt_i) begin
          state_q <= PWR_ACTIVE;
          wake_q  <= 1'b1;
        end
      end else if (sleep_req_i) begin
        if (pending_i) begin
          rej_q <= 1'b1;
        end else begin
          rej_q   <= 1'b0;
          state_q <= PWR_DEEP;
        end
      end
    end
  end

  assign state_o     = state_q;
  assign wake_o      = wake_q;
  assign sleep_rej_o = rej_q;
endmodule

// File: rtl/wake_ctrl.sv
module wake_ctrl
  import wake_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned ADDR_W      = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              temp_evt_i,
  input  logic              vdelta_evt_i,
  input  logic              supply_evt_i,
  input  logic              rtc_tick_evt_i,
  input  logic              rtc_alarm_evt_i,
  input  logic              ext0_pin_i,
  input  logic              ext1_pin_i,
  input  logic              rx_pin_i,
  input  logic              ext_rst_ni,
  input  logic              sleep_req_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o,
  output logic [1:0]        pwr_state_o,
  output logic              wake_o,
  output logic              sleep_rej_o
);
  localparam int unsigned NPIN = 4;
  localparam int unsigned P_EXT0 = 0, P_EXT1 = 1, P_RX = 2, P_RST = 3;
  localparam logic [NPIN-1:0] PIN_RST = 4'b1000;

  logic [NPIN-1:0] pin_lvl, pin_rise, pin_fall;
  wake_flags_t     flags;
  wake_cfg_t       cfg;
  logic            temp_en, vdelta_en;
  logic [1:0]      rx_mode;
  logic            rx_armed, rx_edge, ext0_wake, ext1_wake;
  logic            pending, wake_evt, rst_pin_low;
  pwr_state_e      state;

  wake_pin_sync #(
    .N(NPIN), .STAGES(SYNC_STAGES), .RST_VAL(PIN_RST)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pin_i ({ext_rst_ni, rx_pin_i, ext1_pin_i, ext0_pin_i}),
    .lvl_o (pin_lvl),
    .rise_o(pin_rise),
    .fall_o(pin_fall)
  );

  assign rx_armed    = (rx_mode == 2'b11);
  assign rx_edge     = rx_armed & (pin_rise[P_RX] | pin_fall[P_RX]);
  assign ext0_wake   = cfg.ext0_en &
                       (cfg.ext0_rise ? pin_rise[P_EXT0] : pin_fall[P_EXT0]);
  assign ext1_wake   = (cfg.ext1_code[2:1] == 2'b11) &
                       (cfg.ext1_rise ? pin_rise[P_EXT1] : pin_fall[P_EXT1]);
  assign rst_pin_low = ~pin_lvl[P_RST];

  assign pending = (flags.temp & temp_en) | (flags.vdelta & vdelta_en) |
                   flags.supply | (flags.tick & cfg.tick_en) |
                   (flags.alarm & cfg.alarm_en) | (flags.rx & rx_armed);
  assign wake_evt = pending | ext0_wake | ext1_wake;

  wake_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .wr_addr_i   (wr_addr_i),
    .wr_data_i   (wr_data_i),
    .rd_addr_i   (rd_addr_i),
    .rd_data_o   (rd_data_o),
    .temp_evt_i  (temp_evt_i),
    .vdelta_evt_i(vdelta_evt_i),
    .supply_evt_i(supply_evt_i),
    .tick_evt_i  (rtc_tick_evt_i),
    .alarm_evt_i (rtc_alarm_evt_i),
    .rx_edge_i   (rx_edge),
    .state_i     (state),
    .sleep_rej_i (sleep_rej_o),
    .flags_o     (flags),
    .temp_en_o   (temp_en),
    .vdelta_en_o (vdelta_en),
    .cfg_o       (cfg),
    .rx_mode_o   (rx_mode)
  );

  wake_seq u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sleep_req_i  (sleep_req_i),
    .pending_i    (pending),
    .wake_evt_i   (wake_evt),
    .rst_pin_low_i(rst_pin_low),
    .state_o      (state),
    .wake_o       (wake_o),
    .sleep_rej_o  (sleep_rej_o)
  );

  assign pwr_state_o = state;
endmodule

// File: rtl/wake_ctrl_chk.sv
module wake_ctrl_chk
  import wake_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sleep_req_i,
  input logic       supply_evt_i,
  input logic [1:0] pwr_state_i,
  input logic       wake_i,
  input logic       sleep_rej_i,
  input logic       pending_i,
  input logic       wake_evt_i,
  input logic       rst_pin_low_i,
  input logic       supply_flag_i
);
  // R2
  sleep_enter_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sleep_req_i && pwr_state_i != PWR_DEEP && !pending_i)
      |=> (pwr_state_i == PWR_DEEP && !sleep_rej_i));

  // R3
  sleep_refuse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sleep_req_i && pwr_state_i != PWR_DEEP && pending_i)
      |=> (pwr_state_i == $past(pwr_state_i) && sleep_rej_i));

  // R4
  supply_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    supply_evt_i |=> supply_flag_i);

  // R11
  rst_pin_light_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_state_i == PWR_DEEP && rst_pin_low_i)
      |=> (pwr_state_i == PWR_LIGHT && wake_i));

  // R12
  wake_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_i |=> !wake_i);

  // R12
  wake_origin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_i |-> ($past(pwr_state_i) == PWR_DEEP && pwr_state_i != PWR_DEEP));

  // R12
  deep_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_state_i == PWR_DEEP && !wake_evt_i && !rst_pin_low_i)
      |=> (pwr_state_i == PWR_DEEP && !wake_i));
endmodule

bind wake_ctrl wake_ctrl_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .sleep_req_i  (sleep_req_i),
  .supply_evt_i (supply_evt_i),
  .pwr_state_i  (pwr_state_o),
  .wake_i       (wake_o),
  .sleep_rej_i  (sleep_rej_o),
  .pending_i    (pending),
  .wake_evt_i   (wake_evt),
  .rst_pin_low_i(rst_pin_low),
  .supply_flag_i(flags.supply)
);

// File: tb/wake_ctrl_test.sv
`timescale 1ns/1ps
module wake_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic temp_evt = 0, vdelta_evt = 0, supply_evt = 0, tick_evt = 0, alarm_evt = 0;
  logic ext0 = 0, ext1 = 0, rx = 0, ext_rst_n = 1, sleep_req = 0;
  logic wr_en = 0;
  logic [2:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0, rd_data;
  logic [1:0] pwr_state;
  logic wake, sleep_rej;

  int checks = 0, fails = 0, wake_cnt = 0, base = 0;
  logic [7:0] r;
  bit done = 0;

  always #2.5 clk = ~clk;

  wake_ctrl #(.SYNC_STAGES(2), .ADDR_W(3)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .temp_evt_i(temp_evt), .vdelta_evt_i(vdelta_evt), .supply_evt_i(supply_evt),
    .rtc_tick_evt_i(tick_evt), .rtc_alarm_evt_i(alarm_evt),
    .ext0_pin_i(ext0), .ext1_pin_i(ext1), .rx_pin_i(rx), .ext_rst_ni(ext_rst_n),
    .sleep_req_i(sleep_req), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .pwr_state_o(pwr_state), .wake_o(wake), .sleep_rej_o(sleep_rej)
  );

  always @(negedge clk) if (wake === 1'b1) wake_cnt++;

  // {event[16:13], pm_en{vdelta,temp}[12:11], wake_cfg[10:3], rx_mode[2:1], expect_wake[0]}
  // events: 0 temp 1 vdelta 2 supply 3 tick 4 alarm 5 ext0 rise 6 ext0 fall
  //         7 ext1 rise 8 ext1 fall 9 rx rise 10 rx fall
  localparam logic [16:0] VECS [19] = '{
    {4'd0,  2'b01, 8'h00, 2'b00, 1'b1},
    {4'd0,  2'b00, 8'h00, 2'b00, 1'b0},
    {4'd1,  2'b10, 8'h00, 2'b00, 1'b1},
    {4'd1,  2'b00, 8'h00, 2'b00, 1'b0},
    {4'd2,  2'b00, 8'h00, 2'b00, 1'b1},
    {4'd3,  2'b00, 8'h40, 2'b00, 1'b1},
    {4'd3,  2'b00, 8'hBF, 2'b00, 1'b0},
    {4'd4,  2'b00, 8'h80, 2'b00, 1'b1},
    {4'd5,  2'b00, 8'h11, 2'b00, 1'b1},
    {4'd6,  2'b00, 8'h01, 2'b00, 1'b1},
    {4'd6,  2'b00, 8'h11, 2'b00, 1'b0},
    {4'd7,  2'b00, 8'h2C, 2'b00, 1'b1},
    {4'd7,  2'b00, 8'h2E, 2'b00, 1'b1},
    {4'd7,  2'b00, 8'h28, 2'b00, 1'b0},
    {4'd8,  2'b00, 8'h0C, 2'b00, 1'b1},
    {4'd9,  2'b00, 8'h00, 2'b11, 1'b1},
    {4'd10, 2'b00, 8'h00, 2'b11, 1'b1},
    {4'd9,  2'b00, 8'h00, 2'b10, 1'b0},
    {4'd5,  2'b00, 8'h10, 2'b00, 1'b0}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic string req_of(input int ev);
    case (ev)
      0: return "R6";
      1: return "R5";
      2: return "R4";
      3, 4: return "R7";
      5, 6: return "R8";
      7, 8: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic do_reset(input logic p0, input logic p1, input logic prx);
    @(negedge clk);
    rst_n = 0; ext0 = p0; ext1 = p1; rx = prx; ext_rst_n = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (6) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); rd_addr = a; #1 d = rd_data;
  endtask

  task automatic sleep();
    @(negedge clk); sleep_req = 1;
    @(negedge clk); sleep_req = 0;
  endtask

  task automatic pulse(input int ev);
    @(negedge clk);
    case (ev)
      0: temp_evt = 1; 1: vdelta_evt = 1; 2: supply_evt = 1;
      3: tick_evt = 1; 4: alarm_evt = 1; default: ;
    endcase
    @(negedge clk);
    temp_evt = 0; vdelta_evt = 0; supply_evt = 0; tick_evt = 0; alarm_evt = 0;
  endtask

  task automatic fire(input int ev);
    if (ev <= 4) pulse(ev);
    else begin
      @(negedge clk);
      case (ev)
        5: ext0 = 1; 6: ext0 = 0; 7: ext1 = 1; 8: ext1 = 0;
        9: rx = 1; default: rx = 0;
      endcase
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    do_reset(0, 0, 0);
    check("R1 state", int'(pwr_state), 0);
    check("R1 wake", int'(wake), 0);
    check("R1 reject", int'(sleep_rej), 0);
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), r);
      check("R1 register", int'(r), 0);
    end

    // table of sources
    for (int i = 0; i < 19; i++) begin
      int ev;
      logic [1:0] pm;
      logic [7:0] cf;
      logic [1:0] rm;
      logic ew;
      ev = int'(VECS[i][16:13]); pm = VECS[i][12:11];
      cf = VECS[i][10:3]; rm = VECS[i][2:1]; ew = VECS[i][0];
      do_reset(ev == 6, ev == 8, ev == 10);
      wr(3'd1, {4'b0, pm[1], 2'b0, pm[0]});
      wr(3'd3, cf);
      wr(3'd4, {6'b0, rm});
      sleep();
      check({req_of(ev), " deep entry"}, int'(pwr_state), 2);
      #1 base = wake_cnt;
      fire(ev);
      repeat (8) @(negedge clk);
      #1;
      check({req_of(ev), " state"}, int'(pwr_state), ew ? 0 : 2);
      check({req_of(ev), " wake count"}, wake_cnt - base, ew ? 1 : 0);
    end

    // R4 restore while active, R12 no pulse outside deep sleep
    do_reset(0, 0, 0);
    #1 base = wake_cnt;
    pulse(2);
    rd(3'd0, r); check("R4 restore flag", int'(r), 'h80);
    rd(3'd4, r); check("R4 rail status", int'(r), 'h40);
    #1 check("R12 no wake while active", wake_cnt - base, 0);
    // R3 refused entry
    sleep();
    check("R3 state kept", int'(pwr_state), 0);
    check("R3 reject bit", int'(sleep_rej), 1);
    rd(3'd5, r); check("R3 status register", int'(r), 'h04);
    // R13 clear
    wr(3'd0, 8'h80);
    rd(3'd0, r); check("R13 cleared", int'(r), 0);
    rd(3'd4, r); check("R4 rail status sticky", int'(r), 'h40);

    // R5 disabled flag does not block, enable during sleep wakes
    pulse(1);
    rd(3'd0, r); check("R5 flag set while masked", int'(r), 'h08);
    #1 base = wake_cnt;
    sleep();
    check("R2 deep entry", int'(pwr_state), 2);
    check("R3 masked flag does not block", int'(sleep_rej), 0);
    repeat (4) @(negedge clk);
    check("R5 masked stays asleep", int'(pwr_state), 2);
    wr(3'd1, 8'h08);
    repeat (3) @(negedge clk);
    #1;
    check("R5 late enable wakes", int'(pwr_state), 0);
    check("R5 one pulse", wake_cnt - base, 1);

    // R13 event beats clear
    wr(3'd0, 8'h08);
    @(negedge clk); wr_en = 1; wr_addr = 3'd0; wr_data = 8'h08; vdelta_evt = 1;
    @(negedge clk); wr_en = 0; vdelta_evt = 0;
    rd(3'd0, r); check("R13 event wins", int'(r), 'h08);
    wr(3'd0, 8'h08);
    rd(3'd0, r); check("R13 clear after", int'(r), 0);

    // R12 exact latency, R7 flag position
    wr(3'd1, 8'h00);
    wr(3'd3, 8'h40);
    sleep();
    check("R2 deep", int'(pwr_state), 2);
    #1 base = wake_cnt;
    @(negedge clk); tick_evt = 1;
    @(negedge clk); tick_evt = 0;
    check("R12 no wake yet", int'(wake), 0);
    @(negedge clk);
    check("R12 wake pulse", int'(wake), 1);
    check("R12 active on wake", int'(pwr_state), 0);
    @(negedge clk);
    check("R12 pulse ends", int'(wake), 0);
    rd(3'd2, r); check("R7 interval flag", int'(r), 'h04);
    pulse(4);
    rd(3'd2, r); check("R7 alarm flag", int'(r), 'h44);
    #1 check("R12 one pulse per episode", wake_cnt - base, 1);
    sleep();
    check("R3 armed tick blocks", int'(pwr_state), 0);
    wr(3'd2, 8'h44);
    rd(3'd2, r); check("R13 rtc cleared", int'(r), 0);

    // R8 pin wake leaves flags alone
    wr(3'd3, 8'h11);
    sleep();
    @(negedge clk); ext0 = 1;
    repeat (5) @(negedge clk);
    check("R8 pin wake", int'(pwr_state), 0);
    rd(3'd0, r); check("R8 no power flag", int'(r), 0);
    rd(3'd2, r); check("R8 no rtc flag", int'(r), 0);
    rd(3'd4, r); check("R8 no periph flag", int'(r), 'h40);
    @(negedge clk); ext0 = 0;
    repeat (4) @(negedge clk);

    // R11 reset pin beats a same-cycle supply restore
    wr(3'd3, 8'h00);
    sleep();
    check("R11 deep", int'(pwr_state), 2);
    #1 base = wake_cnt;
    @(negedge clk); ext_rst_n = 0;
    pulse(2);
    @(negedge clk);
    check("R11 intermediate state", int'(pwr_state), 1);
    #1 check("R11 wake pulse", wake_cnt - base, 1);
    ext_rst_n = 1;
    sleep();
    check("R3 refused from intermediate", int'(pwr_state), 1);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule